// File: doc/BRIEF.md
# External Interrupt Request Latch

This block collects external interrupt requests for a small 8-bit processor and keeps them in one pending latch. There are two kinds of source. One is a dedicated active-low request pin. The other is a group of port pins, which join the same path when a configuration bit enables them. Every raw input first passes through its own flop synchronizer. The synchronized levels are then ANDed into one active-low combined line, so a low on any enabled source pulls that line low. A falling edge on the combined line sets the latch. In level mode, a low level on the line also sets it.

The latch raises a request to the processor only when the software enable bit is set and the processor's global mask is clear. When the processor fetches the interrupt vector, it pulses an acknowledge strobe that clears the latch. Software can also clear the latch through a control write. A set condition arriving in the same cycle as a clear takes priority, so no request is lost. The vector addresses for the service routine are constant outputs. The processor is expected to sample the request only between instructions.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, `pending` and `irq_req` are 0. The enable bit resets to 1, so once a request is latched with `cpu_mask`=0, `irq_req` is 1 without any control write.
- R2: A falling edge on `irq_pin_n` sets `pending` on the third rising clock edge after the pin changes: two synchronizer stages, then the latch.
- R3: With `cfg_level`=0 (edge only), a source held low does not set `pending` again after it has been cleared.
- R4: With `cfg_level`=1 (edge plus level), `pending` is set on every cycle in which the combined line is low. A clear while any source is held low therefore leaves `pending` at 1.
- R5: With `cfg_port_en`=0, the `port_pin_n` inputs have no effect on `pending`. With `cfg_port_en`=1, a falling edge on any one of the four port pins sets `pending`, just as the dedicated pin does.
- R6: Edges are detected on the combined line only. In edge mode, a second source falling while another source is already low does not set `pending`.
- R7: `irq_req` is 1 exactly when `pending`=1, the enable bit is 1 and `cpu_mask`=0.
- R8: A `vec_fetch` pulse, or a `ctl_wr` with `ctl_wdata_ack`=1, clears `pending` on that clock edge. A set condition on the same edge wins.
- R9: `vec_hi_addr` reads 16'h07FA and `vec_lo_addr` reads 16'h07FB.
- R10: A rising edge on any source never sets `pending`.
- R11: A `ctl_wr` loads the enable bit from `ctl_wdata_en`. Clearing the enable bit blocks `irq_req` but leaves `pending` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_n | input | 1 | Dedicated request pin, active low, asynchronous |
| port_pin_n | input | 4 | Port pins usable as extra sources, active low, asynchronous |
| cfg_port_en | input | 1 | 1 adds the port pins to the combined line |
| cfg_level | input | 1 | 0 selects falling edge only; 1 selects falling edge plus low level |
| cpu_mask | input | 1 | Global interrupt mask of the processor |
| vec_fetch | input | 1 | Vector-fetch acknowledge strobe; clears the latch |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata_en | input | 1 | Enable bit value written on `ctl_wr` |
| ctl_wdata_ack | input | 1 | 1 on `ctl_wr` clears the latch |
| pending | output | 1 | Latched request status |
| irq_req | output | 1 | Interrupt request to the processor |
| vec_hi_addr | output | 16 | Address of the vector high byte |
| vec_hi_addr | output | 16 | Address of the vector high byte |
| vec_lo_addr | output | 16 | Address of the vector low byte |

## Verification
The bench sweeps every source against both port-enable settings and both sensitivities. A design that ignored the port enable, or dropped a port pin from the combined line, would latch the wrong set of sources. It checks the set-wins collision between a clear and a fresh edge by placing the clear on the exact edge where the edge is detected; a clear-wins design would lose that request. It holds a source low across a clear in both modes, and drops a second source while the first is still low. A level-style design would then re-set in edge mode, and a per-pin edge detector would fire spuriously. Rising edges, the enable and mask gating, and the two-stage latency are each sampled on the exact cycle the requirements imply.

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
  parameter int NPORT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_HI = 16'h07FA,
  parameter logic [ADDR_W-1:0] VEC_LO = 16'h07FB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pin_n,
  input  logic [NPORT-1:0]  port_pin_n,
  input  logic              cfg_port_en,
  input  logic              cfg_level,
  input  logic              cpu_mask,
  input  logic              vec_fetch,
  input  logic              ctl_wr,
  input  logic              ctl_wdata_en,
  input  logic              ctl_wdata_ack,
  output logic              pending,
  output logic              irq_req,
  output logic [ADDR_W-1:0] vec_hi_addr,
  output logic [ADDR_W-1:0] vec_lo_addr
);
  localparam int NIN = NPORT + 1;

  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic [NIN-1:0] lvl;
  logic           comb_n, comb_q_n, fall, set_req, clr_req, irq_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
    end else begin
      sync_q[0] <= {port_pin_n, irq_pin_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign lvl     = sync_q[SYNC_STAGES-1];
  assign comb_n  = lvl[0] & (cfg_port_en ? &lvl[NIN-1:1] : 1'b1);
  assign fall    = comb_q_n & ~comb_n;
  assign set_req = fall | (cfg_level & ~comb_n);
  assign clr_req = vec_fetch | (ctl_wr & ctl_wdata_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comb_q_n <= 1'b1;
      pending  <= 1'b0;
      irq_en_q <= 1'b1;
    end else begin
      comb_q_n <= comb_n;
      if (set_req)      pending <= 1'b1;
      else if (clr_req) pending <= 1'b0;
      if (ctl_wr) irq_en_q <= ctl_wdata_en;
    end
  end

  assign irq_req     = pending & irq_en_q & ~cpu_mask;
  assign vec_hi_addr = VEC_HI;
  assign vec_lo_addr = VEC_LO;
endmodule

module ext_irq_latch_chk (
  input logic clk,
  input logic rst_n,
  input logic pending,
  input logic irq_req,
  input logic cpu_mask,
  input logic vec_fetch,
  input logic ctl_wr,
  input logic ctl_wdata_ack,
  input logic cfg_level,
  input logic comb_n,
  input logic comb_q_n
);
  // R7
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pending && !cpu_mask));
  // R8
  clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(vec_fetch || (ctl_wr && ctl_wdata_ack)));
  // R10
  set_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> !$past(comb_n));
  // R3
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pending) && !$past(cfg_level)) |-> $past(comb_q_n));
  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_level) && !$past(comb_n)) |-> pending);
endmodule

bind ext_irq_latch ext_irq_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pending(pending), .irq_req(irq_req),
  .cpu_mask(cpu_mask), .vec_fetch(vec_fetch), .ctl_wr(ctl_wr),
  .ctl_wdata_ack(ctl_wdata_ack), .cfg_level(cfg_level),
  .comb_n(comb_n), .comb_q_n(comb_q_n)
);

// File: tb/ext_irq_latch_tb.sv
module ext_irq_latch_tb;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic irq_pin_n = 1;
  logic [3:0] port_pin_n = '1;
  logic cfg_port_en = 0, cfg_level = 0, cpu_mask = 0, vec_fetch = 0;
  logic ctl_wr = 0, ctl_wdata_en = 1, ctl_wdata_ack = 0;
  logic pending, irq_req;
  logic [15:0] vec_hi_addr, vec_lo_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  ext_irq_latch u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pin_n(port_pin_n),
    .cfg_port_en(cfg_port_en), .cfg_level(cfg_level), .cpu_mask(cpu_mask),
    .vec_fetch(vec_fetch), .ctl_wr(ctl_wr), .ctl_wdata_en(ctl_wdata_en),
    .ctl_wdata_ack(ctl_wdata_ack), .pending(pending), .irq_req(irq_req),
    .vec_hi_addr(vec_hi_addr), .vec_lo_addr(vec_lo_addr)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(int src, logic v);
    if (src == 0) irq_pin_n = v; else port_pin_n[src-1] = v;
  endtask

  task automatic fetch();
    vec_fetch = 1; step(); vec_fetch = 0;
  endtask

  task automatic sw_ack();
    ctl_wr = 1; ctl_wdata_en = 1; ctl_wdata_ack = 1; step();
    ctl_wr = 0; ctl_wdata_ack = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1; step();
    // R1 reset state, R9 vectors
    chk("R1 pending", pending, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R9 hi", vec_hi_addr, 16'h07FA);
    chk("R9 lo", vec_lo_addr, 16'h07FB);

    // R2 latency: set exactly on third edge
    irq_pin_n = 0; step(2);
    chk("R2 not yet", pending, 0);
    step();
    chk("R2 set", pending, 1);
    chk("R1 irq_req enabled after reset", irq_req, 1);
    // R7/R11 gating sweep
    for (int m = 0; m < 4; m++) begin
      cpu_mask = m[0];
      ctl_wr = 1; ctl_wdata_en = m[1]; step(); ctl_wr = 0;
      chk("R7 irq_req gate", irq_req, m[1] & ~m[0]);
      chk("R11 pending kept", pending, 1);
    end
    cpu_mask = 0;
    // R3 held low in edge mode: clear stays clear
    fetch(); step(3);
    chk("R3 held low no reset", pending, 0);
    // R10 rising edge
    irq_pin_n = 1; step(4);
    chk("R10 rise no set", pending, 0);

    // sweep sources x port_en x mode
    for (int lv = 0; lv < 2; lv++)
      for (int pe = 0; pe < 2; pe++)
        for (int s = 0; s < 5; s++) begin
          cfg_level = lv[0]; cfg_port_en = pe[0]; step(3);
          sw_ack(); step();
          chk("R8 sw ack clears", pending, 0);
          drive(s, 0); step(3);
          chk(s == 0 ? "R2 pin sets" : "R5 port source", pending, (s == 0 || pe == 1) ? 1 : 0);
          fetch();
          chk(lv ? "R4 level holds over clear" : "R8 fetch clears", pending,
              (lv == 1 && (s == 0 || pe == 1)) ? 1 : 0);
          drive(s, 1); step(3); fetch(); step(3);
          chk("R10 release no set", pending, 0);
        end

    // R6 combined edge: second source falling while first low
    cfg_level = 0; cfg_port_en = 1; step(3); fetch(); step();
    irq_pin_n = 0; step(3); fetch(); step();
    chk("R6 first cleared", pending, 0);
    port_pin_n[2] = 0; step(4);
    chk("R6 no second edge", pending, 0);
    irq_pin_n = 1; port_pin_n = '1; step(4); fetch();

    // R8 set wins over coincident clear (edge mode)
    irq_pin_n = 0; step(2); vec_fetch = 1; step(); vec_fetch = 0;
    chk("R8 set wins fetch", pending, 1);
    irq_pin_n = 1; step(3); fetch();
    chk("R8 cleared", pending, 0);
    port_pin_n[0] = 0; step(2);
    ctl_wr = 1; ctl_wdata_en = 1; ctl_wdata_ack = 1; step(); ctl_wr = 0; ctl_wdata_ack = 0;
    chk("R8 set wins sw ack", pending, 1);
    port_pin_n = '1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule